// File: doc/BRIEF.md
# FSK Transmit Tone Generator with Bit Timer

This block turns a serial bit stream into a two-bit quantised audio tone for 1200-baud frequency-shift keying. A sample strobe arrives at 13.2 kHz, one clock wide. On each strobe the block reads a quantised sine code at the current phase and then advances the phase. The size of the step depends on the bit being sent. A one advances 11 positions of a 66-position cycle, which gives a 2200 Hz mark tone. A zero advances 6 positions, which gives a 1200 Hz space tone. Both tones divide the 66-position cycle exactly at this sample rate, so neither tone accumulates a phase error.

A bit period lasts eleven strobes. In the clock after the last strobe of a period, the block raises a one-cycle request. The upstream source then presents the next bit before the following strobe. The block samples the bit only on the first strobe of each period and holds it until the period ends. The phase is never reset when the tone changes, so the output waveform has no jump at a bit edge. The analog network after the two-bit code is outside this block, and so is the serial framing.

Top module: `fsk_tone_gen`

## Requirements
- R1: Synchronous reset sets `tone_code` to 2 and `bit_req` to 0. It also sets the phase to 0, places the bit timer at a period boundary and sets the held bit to 1.
- R2: `tone_code` and the phase change only in a clock where `sample_stb` is high. In clocks without a strobe, every output keeps its value, except that `bit_req` returns to 0.
- R3: While the held bit is 1, each strobe advances the phase by 11.
- R4: While the held bit is 0, each strobe advances the phase by 6.
- R5: The phase stays in the range 0 to 65. When phase plus step reaches 66 or more, 66 is subtracted. A change of tone never resets the phase.
- R6: On each strobe, `tone_code` takes the code of the phase before the advance. The code at phase i is 3 when sin(2πi/66) ≥ 0.5, 2 when 0 ≤ sin < 0.5, 1 when −0.5 ≤ sin < 0, and 0 below −0.5. This gives 2 for i in 0..5 and 28..33, 3 for 6..27, 1 for 34..38 and 61..65, and 0 for 39..60.
- R7: Every bit period lasts exactly 11 strobes, so `bit_req` pulses exactly once for every 11 strobes.
- R8: `tx_bit` is sampled only on the first strobe of a period. Its value at any other clock has no effect on the phase steps or on `tone_code`.
- R9: `bit_req` is high for one clock only: the clock right after the eleventh (last) strobe of a period.
- R10: The first strobe after reset opens a bit period and samples `tx_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-clock sample strobe (13.2 kHz) |
| tx_bit | input | 1 | Bit to send; 1 selects mark, 0 selects space |
| tone_code | output | 2 | Quantised sine code, 0 to 3 |
| bit_req | output | 1 | One-clock pulse asking for the next bit |

## Verification
The generator is driven with four input streams:
- **Steady marks.** This visits only six phases and isolates the step-11 path.
- **Steady spaces.** This visits eleven phases and isolates the step-6 path.
- **Bits alternating each period.** Odd mixes of the two steps walk the whole table, so this exposes wrap errors and any phase reset at a tone change.
- **`tx_bit` toggling on every clock.** The output matches only if the bit is taken on the first strobe of a period alone.

Irregular gaps between strobes show whether anything moves without a strobe. A pulse count taken from reset confirms both the eleven-strobe period and the opening of a period on the first strobe.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

    localparam int CODE_W = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        TONE_SPACE = 1'b0,
        TONE_MARK  = 1'b1
    } tone_e;

    // Code driven while no sample has been produced (mid-scale, phase zero)
    localparam code_t CODE_IDLE = code_t'(2);

    // Per-strobe control bundle handed from the bit timer to the phase path
    typedef struct packed {
        logic  stb;
        logic  boundary;
        tone_e bit_in;
    } sample_req_t;

    // Four-level quantised sine of phase idx out of len positions.
    // Thresholds are worked in twelfths of the cycle, so only integer maths is needed.
    function automatic code_t sine_code(input int idx, input int len);
        int a12;
        a12 = 12 * idx;
        if (2 * idx <= len) begin
            return (a12 >= len && a12 <= 5 * len) ? code_t'(3) : code_t'(2);
        end
        return (a12 > 7 * len && a12 < 11 * len) ? code_t'(0) : code_t'(1);
    endfunction

endpackage

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut
    import fsk_tone_pkg::*;
#(
    parameter int TABLE_LEN = 66,
    parameter int PHASE_W   = $clog2(TABLE_LEN)
) (
    input  logic [PHASE_W-1:0] idx,
    output code_t              code
);
    localparam logic [PHASE_W-1:0] LAST_IDX = PHASE_W'(TABLE_LEN - 1);

    code_t table_q [TABLE_LEN];

    for (genvar g = 0; g < TABLE_LEN; g++) begin : g_entry
        assign table_q[g] = sine_code(g, TABLE_LEN);
    end

    always_comb begin
        if (idx <= LAST_IDX) code = table_q[idx];
        else                 code = CODE_IDLE;
    end
endmodule

// File: rtl/fsk_baud_timer.sv
module fsk_baud_timer #(
    parameter int BAUD_SAMPLES = 11,
    parameter int CNT_W        = $clog2(BAUD_SAMPLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic boundary,
    output logic pulse
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BAUD_SAMPLES - 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    assign boundary = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (stb) begin
                if (boundary) begin
                    cnt_q <= RELOAD;
                end else begin
                    cnt_q <= cnt_q - ONE;
                    if (cnt_q == ONE) pulse <= 1'b1;
                end
            end
        end
    end

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= RELOAD);

    // R9
    pulse_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> boundary);

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(cnt_q));
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc
    import fsk_tone_pkg::*;
#(
    parameter int TABLE_LEN  = 66,
    parameter int MARK_STEP  = 11,
    parameter int SPACE_STEP = 6,
    parameter int PHASE_W    = $clog2(TABLE_LEN)
) (
    input  logic               clk,
    input  logic               rst,
    input  sample_req_t        req,
    output logic [PHASE_W-1:0] phase,
    output tone_e              tone
);
    localparam int SUM_W = PHASE_W + 1;
    localparam logic [SUM_W-1:0] LEN_S   = SUM_W'(TABLE_LEN);
    localparam logic [SUM_W-1:0] MARK_S  = SUM_W'(MARK_STEP);
    localparam logic [SUM_W-1:0] SPACE_S = SUM_W'(SPACE_STEP);

    tone_e            held_q;
    tone_e            eff_tone;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;

    // The bit taken at a boundary already governs the step of that same strobe
    assign eff_tone = req.boundary ? req.bit_in : held_q;
    assign sum      = {1'b0, phase} + ((eff_tone == TONE_MARK) ? MARK_S : SPACE_S);
    assign wrapped  = (sum >= LEN_S) ? (sum - LEN_S) : sum;
    assign tone     = held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            held_q <= TONE_MARK;
        end else if (req.stb) begin
            phase <= wrapped[PHASE_W-1:0];
            if (req.boundary) held_q <= req.bit_in;
        end
    end

    // R5
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(phase) < TABLE_LEN);

    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req.stb |=> $stable(phase));

    // R8
    tone_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req.stb && req.boundary) |=> $stable(held_q));

    // R3
    mark_step_chk: assert property (@(posedge clk) disable iff (rst)
        (req.stb && eff_tone == TONE_MARK) |=>
            ((int'(phase) - int'($past(phase)) + TABLE_LEN) % TABLE_LEN) == MARK_STEP);

    // R4
    space_step_chk: assert property (@(posedge clk) disable iff (rst)
        (req.stb && eff_tone == TONE_SPACE) |=>
            ((int'(phase) - int'($past(phase)) + TABLE_LEN) % TABLE_LEN) == SPACE_STEP);
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
    import fsk_tone_pkg::*;
#(
    parameter int TABLE_LEN    = 66,
    parameter int MARK_STEP    = 11,
    parameter int SPACE_STEP   = 6,
    parameter int BAUD_SAMPLES = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_stb,
    input  logic       tx_bit,
    output logic [1:0] tone_code,
    output logic       bit_req
);
    localparam int PHASE_W = $clog2(TABLE_LEN);

    sample_req_t        req;
    logic               boundary;
    logic [PHASE_W-1:0] phase;
    tone_e              tone;
    code_t              lut_code;
    code_t              code_q;

    fsk_baud_timer #(
        .BAUD_SAMPLES(BAUD_SAMPLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .stb     (sample_stb),
        .boundary(boundary),
        .pulse   (bit_req)
    );

    assign req.stb      = sample_stb;
    assign req.boundary = boundary;
    assign req.bit_in   = tone_e'(tx_bit);

    fsk_phase_acc #(
        .TABLE_LEN (TABLE_LEN),
        .MARK_STEP (MARK_STEP),
        .SPACE_STEP(SPACE_STEP),
        .PHASE_W   (PHASE_W)
    ) u_phase (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .phase(phase),
        .tone (tone)
    );

    fsk_sine_lut #(
        .TABLE_LEN(TABLE_LEN),
        .PHASE_W  (PHASE_W)
    ) u_lut (
        .idx (phase),
        .code(lut_code)
    );

    always_ff @(posedge clk) begin
        if (rst)             code_q <= CODE_IDLE;
        else if (sample_stb) code_q <= lut_code;
    end

    assign tone_code = code_q;

    // R2
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> $stable(tone_code));

    // R9
    req_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> !bit_req);

    // R8
    tone_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && boundary) |=> $stable(tone));
endmodule

// File: tb/fsk_tone_gen_tb.sv
module fsk_tone_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_stb = 1'b0;
    logic       tx_bit = 1'b0;
    logic [1:0] tone_code;
    logic       bit_req;

    always #2 clk = ~clk;

    fsk_tone_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .sample_stb(sample_stb),
        .tx_bit    (tx_bit),
        .tone_code (tone_code),
        .bit_req   (bit_req)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1 reset";

    // Behavioural reference state
    int m_phase, m_cnt, m_held, m_code, m_pulse;
    int pulses_seen;
    int tick_no = 0;

    function automatic int ref_code(input int i);
        real s;
        s = $sin(2.0 * 3.14159265358979 * i / 66.0);
        if (s >= 0.5) return 3;
        if (s >= 0.0) return 2;
        if (s >= -0.5) return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_cnt = 0; m_held = 1; m_code = 2; m_pulse = 0;
    endtask

    task automatic model_step(input logic s, input logic b);
        m_pulse = 0;
        if (s) begin
            if (m_cnt == 0) m_held = b;
            m_code  = ref_code(m_phase);
            m_phase = (m_phase + (m_held ? 11 : 6)) % 66;
            if (m_cnt == 0) m_cnt = 10;
            else begin
                m_cnt--;
                if (m_cnt == 0) m_pulse = 1;
            end
        end
    endtask

    // One clock: compare outputs, drive inputs, advance reference after the edge
    task automatic tick(input logic s, input logic b);
        @(negedge clk);
        check(tone_code == m_code[1:0], {tag, " R6 tone_code"}, tone_code, m_code);
        check(bit_req == m_pulse[0], {tag, " R9 bit_req"}, bit_req, m_pulse);
        if (bit_req) pulses_seen++;
        sample_stb = s;
        tx_bit     = b;
        @(posedge clk);
        #1;
        tick_no++;
        if (rst) model_reset();
        else model_step(s, b);
    endtask

    // mode 0 mark, 1 space, 2 alternate per period, 3 toggle each clock, 4 random
    task automatic run(input int nstb, input int mode, input int gap);
        for (int k = 0; k < nstb; k++) begin
            int g;
            logic b;
            g = (gap < 0) ? int'($urandom_range(0, 4)) : gap;
            for (int j = 0; j < g; j++) begin
                b = (mode == 3) ? logic'(tick_no % 2) : logic'(mode == 0);
                tick(1'b0, b);
            end
            case (mode)
                0: b = 1'b1;
                1: b = 1'b0;
                2: b = logic'(pulses_seen % 2);
                3: b = logic'(tick_no % 2);
                default: b = logic'($urandom_range(0, 1));
            endcase
            tick(1'b1, b);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        pulses_seen = 0;
        rst = 1'b1;
        repeat (3) tick(1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        check(tone_code == 2'd2, "R1 reset tone_code", tone_code, 2);
        check(bit_req == 1'b0, "R1 reset bit_req", bit_req, 0);

        // R10 first strobe takes the bit; R7 count pulses over 121 strobes
        tag = "R10 first bit";
        pulses_seen = 0;
        run(121, 1, 2);
        repeat (3) tick(1'b0, 1'b1);
        check(pulses_seen == 11, "R7 pulses per 121 strobes", pulses_seen, 11);

        // R2 gaps: outputs hold while no strobe
        tag = "R2 idle gaps";
        begin
            logic [1:0] held_code;
            @(negedge clk);
            held_code = tone_code;
            repeat (20) tick(1'b0, 1'b1);
            check(tone_code == held_code, "R2 tone_code held", tone_code, held_code);
        end

        tag = "R3 mark";
        run(300, 0, 1);
        tag = "R4 space";
        run(300, 1, 0);
        tag = "R5 alternating";
        run(700, 2, 2);
        tag = "R8 toggling tx_bit";
        run(400, 3, 3);
        tag = "R5 random bits";
        run(700, 4, -1);

        repeat (4) tick(1'b0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule